// File: doc/BRIEF.md
# Dead-Source Closing Permission

This block decides whether a circuit breaker may be closed when one or both of its sides carry no voltage. It receives the voltage magnitude of the reference side and of the synchronising side as unsigned words, together with a dead level and a live level. Each side is classified as dead, live or neither.

Three closing combinations can each be enabled on their own:
- both sides dead;
- reference live with synchronising dead;
- reference dead with synchronising live.

The enabled combinations are ORed into a candidate condition. Four veto inputs can suppress that candidate: a general voltage-transformer alarm, a synchronising-side transformer alarm, a dead-check block and a block of the whole synchronising function.

The qualified condition then drives a pickup timer that counts one-millisecond strobes. The permission output rises only after the condition has held for the programmed number of strobes. It falls in the same cycle the condition is lost.

Top module: `dead_charge_check`

## Requirements
- R1: A side is dead only when its magnitude is strictly below `dead_lvl`. A magnitude equal to `dead_lvl` is not dead.
- R2: A side is live only when its magnitude is strictly above `live_lvl`. A magnitude equal to `live_lvl` is not live, and a side between the two levels is neither dead nor live.
- R3: With `en_both_dead` set, both sides dead forms the candidate condition.
- R4: With `en_ref_live` set, a live reference side and a dead synchronising side form the candidate condition.
- R5: With `en_syn_live` set, a dead reference side and a live synchronising side form the candidate condition.
- R6: A combination whose enable is clear contributes nothing, even when its voltage pattern is present.
- R7: Any one of `vt_alarm`, `syn_vt_alarm`, `dead_blk` or `sync_blk` forces `ok_o` low in the same cycle.
- R8: `ok_o` rises only after the qualified condition has been true on `pickup_ms` clock edges where `ms_tick` was high, with no break in between. With `pickup_ms` = 0, `ok_o` follows the qualified condition with no delay.
- R9: When the qualified condition drops, `ok_o` falls in that same cycle, and the strobe count restarts from zero.
- R10: While `rst` is high, `ok_o` is low. A synchronous reset clears the strobe count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| ref_mag | input | VW | Reference-side voltage magnitude |
| syn_mag | input | VW | Synchronising-side voltage magnitude |
| dead_lvl | input | VW | Dead threshold (strict less-than) |
| live_lvl | input | VW | Live threshold (strict greater-than) |
| en_both_dead | input | 1 | Enable: both sides dead |
| en_ref_live | input | 1 | Enable: reference live, synchronising dead |
| en_syn_live | input | 1 | Enable: reference dead, synchronising live |
| vt_alarm | input | 1 | General transformer supervision alarm (veto) |
| syn_vt_alarm | input | 1 | Synchronising-side transformer alarm (veto) |
| dead_blk | input | 1 | Dead-check block (veto) |
| sync_blk | input | 1 | Synchronising-function block (veto) |
| pickup_ms | input | TW | Pickup time in strobes |
| ok_o | output | 1 | Dead-charge closing permitted |

## Verification
The bench probes magnitudes exactly at each threshold and one count inside it. A design using non-strict comparisons would then grant permission at equality. A mode left enabled, or enables mapped to the wrong combination, shows up as a pattern that grants permission when its enable is clear, or that fails to grant it when set.

Each veto is raised alone. A design that ignores any one of them keeps the output high.

The pickup check breaks the condition partway through the count. A timer that only pauses, instead of restarting, would then rise after too few strobes. A timer with a delayed dropout would keep the output high for a cycle after the condition is lost.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef struct packed {
        logic dead;
        logic live;
    } side_st_t;

    typedef struct packed {
        logic both_dead;
        logic ref_live;
        logic syn_live;
    } mode_en_t;

    typedef struct packed {
        logic vt;
        logic syn_vt;
        logic dead_blk;
        logic sync_blk;
    } veto_t;

    localparam int NSIDES = 2;
    localparam int SIDE_REF = 0;
    localparam int SIDE_SYN = 1;

    function automatic logic veto_any(input veto_t v);
        return v.vt | v.syn_vt | v.dead_blk | v.sync_blk;
    endfunction

endpackage

// File: rtl/dcc_side_classify.sv
module dcc_side_classify
    import dcc_pkg::*;
#(
    parameter int VW = 16
) (
    input  logic [VW-1:0] mag,
    input  logic [VW-1:0] dead_lvl,
    input  logic [VW-1:0] live_lvl,
    output side_st_t      st
);
    always_comb begin
        st.dead = (mag < dead_lvl);
        st.live = (mag > live_lvl);
    end
endmodule

// File: rtl/dcc_mode_select.sv
module dcc_mode_select
    import dcc_pkg::*;
(
    input  side_st_t ref_st,
    input  side_st_t syn_st,
    input  mode_en_t en,
    output logic     cand
);
    logic both_dead_hit, ref_live_hit, syn_live_hit;

    always_comb begin
        both_dead_hit = en.both_dead & ref_st.dead & syn_st.dead;
        ref_live_hit  = en.ref_live  & ref_st.live & syn_st.dead;
        syn_live_hit  = en.syn_live  & ref_st.dead & syn_st.live;
        cand          = both_dead_hit | ref_live_hit | syn_live_hit;
    end
endmodule

// File: rtl/dcc_pickup_timer.sv
module dcc_pickup_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          qual,
    input  logic [TW-1:0] delay,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !qual) begin
            cnt <= '0;
        end else if (tick && (cnt < delay)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = qual & ~rst & (cnt >= delay);

    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        !qual |=> (cnt == '0));

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (cnt == '0));

    a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (qual && !tick) |=> $stable(cnt));
endmodule

// File: rtl/dead_charge_check.sv
module dead_charge_check
    import dcc_pkg::*;
#(
    parameter int VW = 16,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ms_tick,
    input  logic [VW-1:0] ref_mag,
    input  logic [VW-1:0] syn_mag,
    input  logic [VW-1:0] dead_lvl,
    input  logic [VW-1:0] live_lvl,
    input  logic          en_both_dead,
    input  logic          en_ref_live,
    input  logic          en_syn_live,
    input  logic          vt_alarm,
    input  logic          syn_vt_alarm,
    input  logic          dead_blk,
    input  logic          sync_blk,
    input  logic [TW-1:0] pickup_ms,
    output logic          ok_o
);
    logic [VW-1:0] mags [NSIDES];
    side_st_t      sts  [NSIDES];
    mode_en_t      en;
    veto_t         veto;
    logic          cand, qual;

    assign mags[SIDE_REF] = ref_mag;
    assign mags[SIDE_SYN] = syn_mag;

    for (genvar g = 0; g < NSIDES; g++) begin : g_side
        dcc_side_classify #(.VW(VW)) u_cls (
            .mag      (mags[g]),
            .dead_lvl (dead_lvl),
            .live_lvl (live_lvl),
            .st       (sts[g])
        );
    end

    assign en   = '{both_dead: en_both_dead, ref_live: en_ref_live, syn_live: en_syn_live};
    assign veto = '{vt: vt_alarm, syn_vt: syn_vt_alarm, dead_blk: dead_blk, sync_blk: sync_blk};

    dcc_mode_select u_mode (
        .ref_st (sts[SIDE_REF]),
        .syn_st (sts[SIDE_SYN]),
        .en     (en),
        .cand   (cand)
    );

    assign qual = cand & ~veto_any(veto);

    dcc_pickup_timer #(.TW(TW)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .tick  (ms_tick),
        .qual  (qual),
        .delay (pickup_ms),
        .done  (ok_o)
    );

    a_r7_veto_blocks: assert property (@(posedge clk) disable iff (rst)
        (vt_alarm || syn_vt_alarm || dead_blk || sync_blk) |-> !ok_o);

    a_r6_ok_needs_candidate: assert property (@(posedge clk) disable iff (rst)
        ok_o |-> cand);

    a_r10_low_in_reset: assert property (@(posedge clk)
        rst |-> !ok_o);
endmodule

// File: tb/sim_dead_charge_check.sv
module sim_dead_charge_check;
    localparam int VW = 16;
    localparam int TW = 16;
    localparam int NV = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ms_tick = 1'b0;
    logic [VW-1:0] ref_mag = '0, syn_mag = '0;
    logic [VW-1:0] dead_lvl = 16'd100, live_lvl = 16'd200;
    logic          en_both_dead = 1'b0, en_ref_live = 1'b0, en_syn_live = 1'b0;
    logic          vt_alarm = 1'b0, syn_vt_alarm = 1'b0, dead_blk = 1'b0, sync_blk = 1'b0;
    logic [TW-1:0] pickup_ms = '0;
    logic          ok_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dead_charge_check #(.VW(VW), .TW(TW)) u0 (
        .clk(clk), .rst(rst), .ms_tick(ms_tick),
        .ref_mag(ref_mag), .syn_mag(syn_mag),
        .dead_lvl(dead_lvl), .live_lvl(live_lvl),
        .en_both_dead(en_both_dead), .en_ref_live(en_ref_live), .en_syn_live(en_syn_live),
        .vt_alarm(vt_alarm), .syn_vt_alarm(syn_vt_alarm),
        .dead_blk(dead_blk), .sync_blk(sync_blk),
        .pickup_ms(pickup_ms), .ok_o(ok_o)
    );

    // {ref[15:0], syn[15:0], en{both_dead,ref_live,syn_live}, veto{vt,syn_vt,dead_blk,sync_blk}, exp}
    localparam logic [39:0] VEC [NV] = '{
        {16'd50,  16'd50,  3'b100, 4'b0000, 1'b1}, // R3
        {16'd50,  16'd50,  3'b000, 4'b0000, 1'b0}, // R6
        {16'd250, 16'd50,  3'b010, 4'b0000, 1'b1}, // R4
        {16'd250, 16'd50,  3'b101, 4'b0000, 1'b0}, // R6
        {16'd50,  16'd250, 3'b001, 4'b0000, 1'b1}, // R5
        {16'd50,  16'd250, 3'b110, 4'b0000, 1'b0}, // R6
        {16'd100, 16'd50,  3'b100, 4'b0000, 1'b0}, // R1 equal is not dead
        {16'd99,  16'd99,  3'b100, 4'b0000, 1'b1}, // R1
        {16'd200, 16'd50,  3'b010, 4'b0000, 1'b0}, // R2 equal is not live
        {16'd201, 16'd99,  3'b010, 4'b0000, 1'b1}, // R2
        {16'd150, 16'd50,  3'b111, 4'b0000, 1'b0}, // R2 between levels
        {16'd250, 16'd250, 3'b111, 4'b0000, 1'b0}, // R6 both live
        {16'd50,  16'd50,  3'b111, 4'b1000, 1'b0}, // R7 vt_alarm
        {16'd50,  16'd50,  3'b111, 4'b0100, 1'b0}, // R7 syn_vt_alarm
        {16'd50,  16'd50,  3'b111, 4'b0010, 1'b0}, // R7 dead_blk
        {16'd50,  16'd50,  3'b111, 4'b0001, 1'b0}  // R7 sync_blk
    };

    task automatic check(input logic exp, input string req);
        checks++;
        if (ok_o !== exp) begin
            fails++;
            $display("FAIL %s: ok_o=%b expected %b", req, ok_o, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
    endtask

    task automatic set_both_dead();
        ref_mag = 16'd50; syn_mag = 16'd50;
        en_both_dead = 1'b1; en_ref_live = 1'b0; en_syn_live = 1'b0;
        {vt_alarm, syn_vt_alarm, dead_blk, sync_blk} = 4'b0000;
    endtask

    initial begin
        // R10: output low while reset is held, even with a qualifying pattern and zero delay
        set_both_dead();
        repeat (3) @(negedge clk);
        check(1'b0, "R10");
        @(negedge clk) rst = 1'b0;
        pickup_ms = '0;

        // Vector table, zero pickup time
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {ref_mag, syn_mag, en_both_dead, en_ref_live, en_syn_live,
             vt_alarm, syn_vt_alarm, dead_blk, sync_blk} = VEC[i][39:1];
            @(negedge clk);
            check(VEC[i][0], $sformatf("R1-6/7 vector %0d", i));
        end

        // R8: pickup of three strobes
        @(negedge clk);
        set_both_dead();
        pickup_ms = 16'd3;
        @(negedge clk);
        check(1'b0, "R8 before any strobe");
        pulse_tick();
        pulse_tick();
        check(1'b0, "R8 after two strobes");
        repeat (3) @(negedge clk);
        check(1'b0, "R8 no strobe no progress");
        pulse_tick();
        check(1'b1, "R8 after three strobes");

        // R9: zero dropout, restart of the count
        ref_mag = 16'd150;
        #1;
        check(1'b0, "R9 immediate drop");
        @(negedge clk);
        ref_mag = 16'd50;
        pulse_tick();
        pulse_tick();
        check(1'b0, "R9 count restarted");
        pulse_tick();
        check(1'b1, "R9 repickup after full count");

        // R7: veto during pickup drops output and restarts the count
        dead_blk = 1'b1;
        #1;
        check(1'b0, "R7 veto drops output");
        @(negedge clk) dead_blk = 1'b0;
        pulse_tick();
        check(1'b0, "R7 count restarted after veto");

        // R10: synchronous reset clears the count
        pulse_tick();
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        pulse_tick();
        pulse_tick();
        check(1'b0, "R10 count cleared by reset");
        pulse_tick();
        check(1'b1, "R10 full count after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule